// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the general registers of a 32-bit processor core and selects the physical copy behind each logical register number from a 3-bit processor-mode input. It has two combinational read ports and one synchronous write port. Each port takes a 4-bit logical register number, and all three ports use the same mode input.

Logical registers 0 to 7 and register 15 (the program counter) have one physical copy that every mode shares. Registers 8 to 12 have two copies: one for the fast-interrupt mode and one for all other modes. Register 13 (stack pointer) and register 14 (link register) have one copy per mode, except that user and system modes share a copy.

Each of the five exception modes also has its own saved-status word. This word is reached through a dedicated write strobe, write data and read data port, and always refers to the current mode. The block does not generate status flags, decode instructions or advance the program counter.

Top module: `bankedRegFile`

## Requirements
- R1: Logical registers 0 to 7 have one physical copy each. A write in any mode is seen by reads in every mode.
- R2: Logical registers 8 to 12 have one copy for mode code 1 (fast interrupt) and a second copy shared by all other mode codes. A write through one copy leaves the other copy unchanged.
- R3: Logical registers 13 and 14 have six copies each. Mode codes 0 (user), 6 (system) and 7 (unused, treated as user) share one copy. Codes 1 to 5 each have a private copy.
- R4: Logical register 15 is one physical register shared by every mode code.
- R5: Reads are combinational. A write with `wrEn` high takes effect at the next rising clock edge. A read of the same register in the cycle of the write returns the value from before the write.
- R6: Mode codes 1 to 5 (fast interrupt, interrupt, supervisor, abort, undefined) each own a saved-status word. `ssRdData` shows the word of the current mode. `ssWrEn` updates it at the next edge.
- R7: In mode codes 0, 6 and 7, `ssRdData` reads zero and `ssWrEn` changes no saved-status word.
- R8: While `rstN` is low, every register and every saved-status word is cleared to zero.
- R9: With `wrEn` low, no general register changes, whatever `wrAddr` and `wrData` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| mode | input | 3 | Processor mode code: 0 user, 1 fast interrupt, 2 interrupt, 3 supervisor, 4 abort, 5 undefined, 6 system, 7 treated as user |
| rdAddrA | input | 4 | Logical register number for read port A |
| rdDataA | output | 32 | Read data A |
| rdAddrB | input | 4 | Logical register number for read port B |
| rdDataB | output | 32 | Read data B |
| wrEn | input | 1 | General register write enable |
| wrAddr | input | 4 | Logical register number for the write |
| wrData | input | 32 | Write data |
| ssWrEn | input | 1 | Saved-status write enable for the current mode |
| ssWrData | input | 32 | Saved-status write data |
| ssRdData | output | 32 | Saved-status word of the current mode |

## Verification
The hardest condition to reach is isolation between copies. A register written in one mode must stay intact while a different mode writes the same logical number to its own copy. It must still hold its value when the first mode reads it again later. Directed sequences write a distinct value to the same logical register in each of the eight mode codes and then read every mode back. This exposes any pair of modes that wrongly shares a copy or any mode that wrongly splits one. A long stretch of random mode, address and strobe traffic then checks every read port against a behavioural model on each cycle, including same-cycle read-after-write and saved-status accesses from modes that have none.

// File: rtl/bankRegPkg.sv
package bankRegPkg;
  typedef enum logic [2:0] {
    MODE_USR = 3'd0, MODE_FIQ = 3'd1, MODE_IRQ = 3'd2, MODE_SVC = 3'd3,
    MODE_ABT = 3'd4, MODE_UND = 3'd5, MODE_SYS = 3'd6, MODE_RSV = 3'd7
  } modeT;

  localparam int LOGIC_CNT = 16;
  localparam int LOW_CNT   = 8;
  localparam int HIGH_CNT  = 5;
  localparam int BANK_CNT  = 6;
  localparam int SS_CNT    = 5;
  localparam int FIQ_BASE  = LOW_CNT + HIGH_CNT;
  localparam int SP_BASE   = FIQ_BASE + HIGH_CNT;
  localparam int LR_BASE   = SP_BASE + BANK_CNT;
  localparam int PC_IDX    = LR_BASE + BANK_CNT;
  localparam int PHYS_N    = PC_IDX + 1;
  localparam int PIDX_W    = $clog2(PHYS_N);
  localparam int SSEL_W    = $clog2(SS_CNT);

  typedef struct packed {
    logic              wr;
    logic [PIDX_W-1:0] wrIdx;
    logic [PIDX_W-1:0] rdIdxA;
    logic [PIDX_W-1:0] rdIdxB;
    logic              ssWr;
    logic              ssValid;
    logic [SSEL_W-1:0] ssSel;
  } strobeT;
endpackage

// File: rtl/bankCtrl.sv
module bankCtrl
  import bankRegPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] mode,
  input  logic [3:0] rdAddrA,
  input  logic [3:0] rdAddrB,
  input  logic       wrEn,
  input  logic [3:0] wrAddr,
  input  logic       ssWrEn,
  output strobeT     stb
);
  localparam int SP_NUM = LOW_CNT + HIGH_CNT;
  localparam int LR_NUM = SP_NUM + 1;

  function automatic logic [PIDX_W-1:0] mapIdx(logic [2:0] m, logic [3:0] a);
    int bank;
    int ai;
    int res;
    ai = int'(a);
    bank = (m == MODE_SYS || m == MODE_RSV) ? 0 : int'(m);
    if (ai < LOW_CNT) res = ai;
    else if (ai < SP_NUM) res = (m == MODE_FIQ) ? (FIQ_BASE + ai - LOW_CNT) : ai;
    else if (ai == SP_NUM) res = SP_BASE + bank;
    else if (ai == LR_NUM) res = LR_BASE + bank;
    else res = PC_IDX;
    return PIDX_W'(res);
  endfunction

  logic excMode;
  assign excMode = (mode >= 3'(MODE_FIQ)) && (mode <= 3'(MODE_UND));

  always_comb begin
    stb.wr      = wrEn;
    stb.wrIdx   = mapIdx(mode, wrAddr);
    stb.rdIdxA  = mapIdx(mode, rdAddrA);
    stb.rdIdxB  = mapIdx(mode, rdAddrB);
    stb.ssValid = excMode;
    stb.ssWr    = ssWrEn && excMode;
    stb.ssSel   = excMode ? SSEL_W'(mode - 3'd1) : '0;
  end

  // R2: a fast-interrupt write to 8..12 must land in the private copy
  a_r2_fiq_private: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && mode == MODE_FIQ && wrAddr >= 4'd8 && wrAddr <= 4'd12)
      |-> (int'(stb.wrIdx) >= FIQ_BASE && int'(stb.wrIdx) < SP_BASE));

  // R7: no saved-status strobe leaves this module in user/system modes
  a_r7_ss_gate: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_USR || mode == MODE_SYS || mode == MODE_RSV) |-> !stb.ssWr);

  // R3: user and system resolve stack pointer to the same copy
  a_r3_usr_sys_same: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_SYS && rdAddrA == 4'd13) |-> (int'(stb.rdIdxA) == SP_BASE));
endmodule

// File: rtl/bankData.sv
module bankData
  import bankRegPkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            stb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] ssWrData,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB,
  output logic [DATA_W-1:0] ssRdData
);
  logic [PHYS_N-1:0][DATA_W-1:0] regs;
  logic [SS_CNT-1:0][DATA_W-1:0] ssRegs;

  for (genvar i = 0; i < PHYS_N; i++) begin : g_phys
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) q <= '0;
      else if (stb.wr && int'(stb.wrIdx) == i) q <= wrData;
    end
    assign regs[i] = q;
  end

  for (genvar j = 0; j < SS_CNT; j++) begin : g_ss
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) q <= '0;
      else if (stb.ssWr && int'(stb.ssSel) == j) q <= ssWrData;
    end
    assign ssRegs[j] = q;
  end

  assign rdDataA  = regs[stb.rdIdxA];
  assign rdDataB  = regs[stb.rdIdxB];
  assign ssRdData = stb.ssValid ? ssRegs[stb.ssSel] : '0;

  // R5: a write is visible at the target on the next cycle
  a_r5_write_lands: assert property (@(posedge clk) disable iff (!rstN)
    stb.wr |=> regs[$past(stb.wrIdx)] == $past(wrData));

  // R9: without a write strobe the storage is unchanged
  a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
    !stb.wr |=> $stable(regs));

  // R6: a saved-status write lands in the selected word
  a_r6_ss_lands: assert property (@(posedge clk) disable iff (!rstN)
    stb.ssWr |=> ssRegs[$past(stb.ssSel)] == $past(ssWrData));

  // R7: saved-status read is zero outside exception modes
  a_r7_ss_zero: assert property (@(posedge clk) disable iff (!rstN)
    !stb.ssValid |-> ssRdData == '0);

  // R7: with no saved-status strobe those words keep their values
  a_r7_ss_hold: assert property (@(posedge clk) disable iff (!rstN)
    !stb.ssWr |=> $stable(ssRegs));
endmodule

// File: rtl/bankedRegFile.sv
module bankedRegFile
  import bankRegPkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        mode,
  input  logic [3:0]        rdAddrA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [3:0]        rdAddrB,
  output logic [DATA_W-1:0] rdDataB,
  input  logic              wrEn,
  input  logic [3:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              ssWrEn,
  input  logic [DATA_W-1:0] ssWrData,
  output logic [DATA_W-1:0] ssRdData
);
  strobeT stb;

  bankCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .mode(mode),
    .rdAddrA(rdAddrA), .rdAddrB(rdAddrB),
    .wrEn(wrEn), .wrAddr(wrAddr), .ssWrEn(ssWrEn), .stb(stb)
  );

  bankData #(.DATA_W(DATA_W)) u_data (
    .clk(clk), .rstN(rstN), .stb(stb),
    .wrData(wrData), .ssWrData(ssWrData),
    .rdDataA(rdDataA), .rdDataB(rdDataB), .ssRdData(ssRdData)
  );

  // R4: the program counter reads the same in every mode
  a_r4_pc_shared: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddrA == 4'd15 && rdAddrB == 4'd15) |-> rdDataA == rdDataB);
endmodule

// File: tb/test_bankedRegFile.sv
module test_bankedRegFile;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  mode = '0;
  logic [3:0]  rdAddrA = '0, rdAddrB = '0, wrAddr = '0;
  logic [31:0] rdDataA, rdDataB, ssRdData;
  logic        wrEn = 1'b0, ssWrEn = 1'b0;
  logic [31:0] wrData = '0, ssWrData = '0;

  int checks = 0;
  int errors = 0;

  // behavioural model
  logic [31:0] mShared [16];
  logic [31:0] mFast   [16];
  logic [31:0] mSp [8];
  logic [31:0] mLr [8];
  logic [31:0] mSs [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  bankedRegFile i_bankedRegFile (
    .clk(clk), .rstN(rstN), .mode(mode),
    .rdAddrA(rdAddrA), .rdDataA(rdDataA),
    .rdAddrB(rdAddrB), .rdDataB(rdDataB),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .ssWrEn(ssWrEn), .ssWrData(ssWrData), .ssRdData(ssRdData)
  );

  function automatic int canon(logic [2:0] m);
    return (m == 3'd6 || m == 3'd7) ? 0 : int'(m);
  endfunction

  function automatic logic [31:0] mRead(logic [2:0] m, logic [3:0] a);
    if (a == 4'd13) return mSp[canon(m)];
    if (a == 4'd14) return mLr[canon(m)];
    if (a >= 4'd8 && a <= 4'd12 && m == 3'd1) return mFast[a];
    return mShared[a];
  endfunction

  function automatic logic [31:0] mSsRead(logic [2:0] m);
    return (m >= 3'd1 && m <= 3'd5) ? mSs[m] : 32'd0;
  endfunction

  function automatic string reqOf(logic [3:0] a);
    if (a < 4'd8) return "R1";
    if (a < 4'd13) return "R2";
    if (a < 4'd15) return "R3";
    return "R4";
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h (mode %0d)", req, got, exp, mode);
    end
  endtask

  // drive one cycle, compare before the edge, update model after it
  task automatic step(logic [2:0] m, logic [3:0] ra, logic [3:0] rb,
                      logic we, logic [3:0] wa, logic [31:0] wd,
                      logic sse, logic [31:0] ssd);
    @(negedge clk);
    mode = m; rdAddrA = ra; rdAddrB = rb;
    wrEn = we; wrAddr = wa; wrData = wd;
    ssWrEn = sse; ssWrData = ssd;
    #1;
    chk(reqOf(ra), rdDataA, mRead(m, ra));
    chk(reqOf(rb), rdDataB, mRead(m, rb));
    chk((m >= 3'd1 && m <= 3'd5) ? "R6" : "R7", ssRdData, mSsRead(m));
    @(posedge clk);
    if (we) begin
      if (wa == 4'd13) mSp[canon(m)] = wd;
      else if (wa == 4'd14) mLr[canon(m)] = wd;
      else if (wa >= 4'd8 && wa <= 4'd12 && m == 3'd1) mFast[wa] = wd;
      else mShared[wa] = wd;
    end
    if (sse && m >= 3'd1 && m <= 3'd5) mSs[m] = ssd;
  endtask

  task automatic idle();
    @(negedge clk);
    wrEn = 1'b0; ssWrEn = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin mShared[i] = '0; mFast[i] = '0; end
    for (int i = 0; i < 8; i++) begin mSp[i] = '0; mLr[i] = '0; mSs[i] = '0; end
    repeat (3) @(posedge clk);
    #1;
    // R8: outputs are zero while held in reset
    chk("R8", rdDataA, 32'd0);
    chk("R8", ssRdData, 32'd0);
    @(negedge clk); rstN = 1'b1;

    // R8: every register in every mode reads zero after reset
    for (int m = 0; m < 8; m++)
      for (int a = 0; a < 16; a += 2) begin
        @(negedge clk);
        mode = 3'(m); rdAddrA = 4'(a); rdAddrB = 4'(a + 1); #1;
        chk("R8", rdDataA, 32'd0);
        chk("R8", rdDataB, 32'd0);
        chk("R8", ssRdData, 32'd0);
      end

    // R3: a distinct stack/link value per mode code, then read all back
    for (int m = 0; m < 8; m++) begin
      step(3'(m), 4'd13, 4'd14, 1'b1, 4'd13, 32'h5000_0000 + 32'(m), 1'b0, '0);
      step(3'(m), 4'd13, 4'd14, 1'b1, 4'd14, 32'h1100_0000 + 32'(m), 1'b0, '0);
    end
    for (int m = 0; m < 8; m++) step(3'(m), 4'd13, 4'd14, 1'b0, '0, '0, 1'b0, '0);

    // R2: fast-interrupt copy of r9 is separate from the shared copy
    step(3'd1, 4'd9, 4'd9, 1'b1, 4'd9, 32'hF1F1_0009, 1'b0, '0);
    step(3'd2, 4'd9, 4'd9, 1'b1, 4'd9, 32'h2222_0009, 1'b0, '0);
    step(3'd1, 4'd9, 4'd12, 1'b0, '0, '0, 1'b0, '0);
    step(3'd0, 4'd9, 4'd12, 1'b0, '0, '0, 1'b0, '0);

    // R1 and R4: write in one mode, read in others
    step(3'd3, 4'd3, 4'd15, 1'b1, 4'd3, 32'hABCD_0003, 1'b0, '0);
    step(3'd3, 4'd3, 4'd15, 1'b1, 4'd15, 32'h0000_8000, 1'b0, '0);
    step(3'd1, 4'd3, 4'd15, 1'b0, '0, '0, 1'b0, '0);
    step(3'd7, 4'd3, 4'd15, 1'b0, '0, '0, 1'b0, '0);

    // R5: same-cycle read of the written register returns old value
    step(3'd4, 4'd5, 4'd13, 1'b1, 4'd5, 32'h1234_5678, 1'b0, '0);
    step(3'd4, 4'd5, 4'd13, 1'b1, 4'd5, 32'h8765_4321, 1'b0, '0);
    step(3'd4, 4'd5, 4'd13, 1'b0, '0, '0, 1'b0, '0);

    // R9: data on the write bus without wrEn changes nothing
    step(3'd0, 4'd6, 4'd15, 1'b0, 4'd6, 32'hDEAD_BEEF, 1'b0, '0);
    step(3'd0, 4'd6, 4'd15, 1'b0, '0, '0, 1'b0, '0);

    // R6: saved status per exception mode
    for (int m = 1; m <= 5; m++) step(3'(m), 4'd0, 4'd0, 1'b0, '0, '0, 1'b1, 32'h0C00_0010 + 32'(m));
    for (int m = 1; m <= 5; m++) step(3'(m), 4'd0, 4'd0, 1'b0, '0, '0, 1'b0, '0);

    // R7: saved-status write in user/system/unused is ignored, reads zero
    step(3'd0, 4'd0, 4'd0, 1'b0, '0, '0, 1'b1, 32'hFFFF_FFFF);
    step(3'd6, 4'd0, 4'd0, 1'b0, '0, '0, 1'b1, 32'hFFFF_FFFF);
    step(3'd7, 4'd0, 4'd0, 1'b0, '0, '0, 1'b1, 32'hFFFF_FFFF);
    for (int m = 0; m < 8; m++) step(3'(m), 4'd0, 4'd0, 1'b0, '0, '0, 1'b0, '0);

    // random traffic against the model
    for (int n = 0; n < 4000; n++)
      step(3'($urandom), 4'($urandom), 4'($urandom), 1'($urandom),
           4'($urandom), $urandom, 1'(($urandom % 4) == 0), $urandom);

    idle();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired (R5 progress) got timeout expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule